// File: doc/BRIEF.md
# Overlapped-Cycle Bus Slave with Block Transfers

This block is the target side of a single-clock on-chip bus. Every operation opens with an address cycle in which the master raises a select line and presents an opcode, a word address and a read flag. The slave then owns the acknowledge lines. It answers first with a fixed number of wait codes and then with one ready code per data word. A single transfer moves one word, and a block transfer moves one word per clock.

Data lands in or comes from a local word array. Byte and halfword writes touch only the lanes that the opcode names. The master may present the next address cycle in the same clock as the last data cycle of the current operation, so chained transfers need no idle clock between them. Select pulses at any other time during an operation are ignored. An opcode with no defined meaning is answered with a single error code.

Top module: `ovl_bus_slave`

## Requirements
- R1: While reset is held and just after it, ack_oe and rdata_oe are 0, ack is 3'b111 and rdata is 0.
- R2: After an accepted address cycle, the slave drives ack 3'b000 (wait) for exactly WAIT_CYC clocks before the first ready code of a non-error operation.
- R3: Ready (3'b001) is given once per data word. opc[4]=0 gives one word. opc[4]=1 gives a block of 2, 4, 8 or 16 words for opc[1:0] = 00, 01, 10, 11, on consecutive clocks.
- R4: Word and block writes store the full 32-bit wdata sampled in each ready clock. Beat i of a block uses address addr+i modulo the array depth, and reads return those words.
- R5: A byte write (opc[4]=0, opc[1:0]=00) changes only byte lane opc[3:2]. A halfword write (opc[1:0]=01) changes bits 31:16 when opc[3]=1 and bits 15:0 otherwise, and opc[2] has no effect. A word op has opc[1:0]=10.
- R6: A read of any size returns the whole addressed 32-bit word.
- R7: opc[4]=0 with opc[1:0]=11 is answered with one error code (3'b010) in the clock after the address cycle, with no wait, no data and no change to the array.
- R8: A select in the final ready or error clock is accepted, and the new operation's wait codes begin in the very next clock.
- R9: A select during a wait clock or a non-final ready clock is ignored: the running operation completes unchanged and no write takes place.
- R10: ack_oe is high exactly in clocks that carry wait, ready or error. When ack_oe is low, ack reads 3'b111. rdata_oe is high only in ready clocks of reads, and rdata is 0 whenever rdata_oe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Slave targeted in this address cycle |
| opc | input | 5 | Operation code: size, block length, lane |
| rd | input | 1 | 1 = read, 0 = write |
| addr | input | AW | Word address |
| wdata | input | 32 | Write data, sampled in ready clocks |
| ack | output | 3 | Acknowledge code: 000 wait, 001 ready, 010 error, 111 idle |
| ack_oe | output | 1 | Slave drives ack this clock |
| rdata | output | 32 | Read data |
| rdata_oe | output | 1 | Slave drives rdata this clock |

## Verification
The address cycle of one operation and the closing data cycle of the previous one can fall in the same clock. The behavioural master provokes this by chaining block writes, block reads, single transfers and error operations back to back. Each new select is raised exactly when the final ready or error code is seen. The clock that follows must already carry the new operation's first wait code, and read data across every boundary is compared against a reference array. Stray selects placed in wait and mid-block clocks show the other side of the rule: they must neither cut the block short nor write.

// File: rtl/ovl_bus_pkg.sv
package ovl_bus_pkg;
  localparam int DW    = 32;
  localparam int NLANE = DW / 8;

  typedef enum logic [2:0] {
    ACK_WAIT = 3'b000,
    ACK_RDY  = 3'b001,
    ACK_ERR  = 3'b010,
    ACK_IDLE = 3'b111
  } ack_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_DATA,
    ST_ERR
  } st_e;

  typedef struct packed {
    logic             bad;
    logic [4:0]       beats;
    logic [NLANE-1:0] mask;
  } opdec_t;
endpackage

// File: rtl/ovl_opdec.sv
module ovl_opdec
  import ovl_bus_pkg::*;
(
  input  logic [4:0] opc,
  output opdec_t     dec
);
  always_comb begin
    dec = '0;
    if (opc[4]) begin
      dec.beats = 5'd2 << opc[1:0];
      dec.mask  = '1;
    end else begin
      dec.beats = 5'd1;
      unique case (opc[1:0])
        2'b00: dec.mask = NLANE'(1) << opc[3:2];
        2'b01: dec.mask = opc[3] ? 4'b1100 : 4'b0011;
        2'b10: dec.mask = '1;
        default: begin
          dec.bad   = 1'b1;
          dec.beats = 5'd0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ovl_mem.sv
module ovl_mem
  import ovl_bus_pkg::*;
#(
  parameter int AW = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [NLANE-1:0] wmask,
  input  logic [DW-1:0]    wdata,
  input  logic [AW-1:0]    raddr,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int l = 0; l < NLANE; l++) begin
        if (wmask[l]) arr[waddr][8*l +: 8] <= wdata[8*l +: 8];
      end
    end
  end

  assign rdata = arr[raddr];
endmodule

// File: rtl/ovl_ctrl.sv
module ovl_ctrl
  import ovl_bus_pkg::*;
#(
  parameter int AW       = 6,
  parameter int WAIT_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  opdec_t           dec,
  input  logic             rd,
  input  logic [AW-1:0]    addr,
  output logic [2:0]       ack,
  output logic             ack_oe,
  output logic             rdata_oe,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [NLANE-1:0] mem_mask
);
  localparam int WCW = $clog2(WAIT_CYC + 2);
  localparam logic [WCW-1:0] WLOAD = WCW'((WAIT_CYC > 0) ? WAIT_CYC - 1 : 0);

  st_e              st_q, st_d;
  logic [WCW-1:0]   wcnt_q, wcnt_d;
  logic [4:0]       left_q, left_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic             rd_q, rd_d;
  logic [NLANE-1:0] mask_q, mask_d;
  logic             last, accept;

  always_comb begin
    last   = (st_q == ST_DATA && left_q == 5'd1) || (st_q == ST_ERR);
    accept = sel && ((st_q == ST_IDLE) || last);

    st_d   = st_q;
    wcnt_d = wcnt_q;
    left_d = left_q;
    addr_d = addr_q;
    rd_d   = rd_q;
    mask_d = mask_q;

    unique case (st_q)
      ST_WAIT: begin
        if (wcnt_q == '0) st_d = ST_DATA;
        else              wcnt_d = wcnt_q - 1'b1;
      end
      ST_DATA: begin
        left_d = left_q - 5'd1;
        addr_d = addr_q + 1'b1;
        if (left_q == 5'd1) st_d = ST_IDLE;
      end
      ST_ERR:  st_d = ST_IDLE;
      default: ;
    endcase

    if (accept) begin
      addr_d = addr;
      rd_d   = rd;
      mask_d = dec.mask;
      left_d = dec.beats;
      wcnt_d = WLOAD;
      if (dec.bad)            st_d = ST_ERR;
      else if (WAIT_CYC == 0) st_d = ST_DATA;
      else                    st_d = ST_WAIT;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wcnt_q <= '0;
      left_q <= '0;
      addr_q <= '0;
      rd_q   <= 1'b0;
      mask_q <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      left_q <= left_d;
      addr_q <= addr_d;
      rd_q   <= rd_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    unique case (st_q)
      ST_WAIT: ack = ACK_WAIT;
      ST_DATA: ack = ACK_RDY;
      ST_ERR:  ack = ACK_ERR;
      default: ack = ACK_IDLE;
    endcase
  end

  assign ack_oe   = (st_q != ST_IDLE);
  assign rdata_oe = (st_q == ST_DATA) && rd_q;
  assign mem_we   = (st_q == ST_DATA) && !rd_q;
  assign mem_addr = addr_q;
  assign mem_mask = mask_q;
endmodule

// File: rtl/ovl_bus_slave.sv
module ovl_bus_slave
  import ovl_bus_pkg::*;
#(
  parameter int AW       = 6,
  parameter int WAIT_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [4:0]    opc,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [2:0]    ack,
  output logic          ack_oe,
  output logic [31:0]   rdata,
  output logic          rdata_oe
);
  opdec_t           dec;
  logic             mem_we;
  logic [AW-1:0]    mem_addr;
  logic [NLANE-1:0] mem_mask;
  logic [DW-1:0]    mem_rdata;

  ovl_opdec u_dec (
    .opc (opc),
    .dec (dec)
  );

  ovl_ctrl #(.AW(AW), .WAIT_CYC(WAIT_CYC)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (sel),
    .dec      (dec),
    .rd       (rd),
    .addr     (addr),
    .ack      (ack),
    .ack_oe   (ack_oe),
    .rdata_oe (rdata_oe),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .mem_mask (mem_mask)
  );

  ovl_mem #(.AW(AW)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_addr),
    .wmask (mem_mask),
    .wdata (wdata),
    .raddr (mem_addr),
    .rdata (mem_rdata)
  );

  assign rdata = rdata_oe ? mem_rdata : '0;
endmodule

// File: rtl/ovl_bus_slave_chk.sv
module ovl_bus_slave_chk #(
  parameter int WAIT_CYC = 2
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  ack,
  input logic        ack_oe,
  input logic [31:0] rdata,
  input logic        rdata_oe
);
  logic [7:0] wrun;
  logic [7:0] rrun;
  logic       prev_wait;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrun      <= '0;
      rrun      <= '0;
      prev_wait <= 1'b0;
    end else begin
      wrun      <= (ack_oe && ack == 3'b000) ? wrun + 8'd1 : 8'd0;
      rrun      <= (ack_oe && ack == 3'b001) ? rrun + 8'd1 : 8'd0;
      prev_wait <= ack_oe && ack == 3'b000;
    end
  end

  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_oe |-> ack == 3'b111); // R10
  AST_RDATA_IN_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_oe |-> (ack_oe && ack == 3'b001)); // R10
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rdata_oe |-> rdata == 32'd0); // R10
  AST_WAIT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && ack == 3'b001 && prev_wait) |-> wrun == 8'(WAIT_CYC)); // R2
  AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && ack == 3'b000) |-> wrun < 8'(WAIT_CYC)); // R2
  AST_BEAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (WAIT_CYC > 0 && ack_oe && ack == 3'b001) |-> rrun < 8'd16); // R3
  AST_ERR_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && ack == 3'b010) |-> !rdata_oe); // R7
endmodule

bind ovl_bus_slave ovl_bus_slave_chk #(.WAIT_CYC(WAIT_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack      (ack),
  .ack_oe   (ack_oe),
  .rdata    (rdata),
  .rdata_oe (rdata_oe)
);

// File: tb/tb_ovl_bus_slave.sv
module tb_ovl_bus_slave;
  localparam int CLK_PERIOD = 10;
  localparam int AW         = 6;
  localparam int DEPTH      = 1 << AW;
  localparam int WAITS      = 2;

  logic          clk;
  logic          rst_n;
  logic          sel;
  logic [4:0]    opc;
  logic          rd;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [2:0]    ack;
  logic          ack_oe;
  logic [31:0]   rdata;
  logic          rdata_oe;

  ovl_bus_slave #(.AW(AW), .WAIT_CYC(WAITS)) dut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .opc(opc), .rd(rd), .addr(addr),
    .wdata(wdata), .ack(ack), .ack_oe(ack_oe), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  int nchk = 0;
  int nerr = 0;
  int cycles = 0;
  int wseq = 1;
  logic [31:0]   ref_m [DEPTH];
  logic [4:0]    op_opc [16];
  logic [AW-1:0] op_addr [16];
  logic          op_rd [16];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      nerr = nerr + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 20000);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int exp_beats(input logic [4:0] o);
    if (o[4]) return 2 << o[1:0];
    return (o[1:0] == 2'b11) ? 0 : 1;
  endfunction

  function automatic logic [31:0] exp_bits(input logic [4:0] o);
    if (o[4] || o[1:0] == 2'b10) return 32'hFFFF_FFFF;
    if (o[1:0] == 2'b00) return 32'h0000_00FF << (8 * o[3:2]);
    return o[3] ? 32'hFFFF_0000 : 32'h0000_FFFF;
  endfunction

  task automatic set_op(input int i, input logic [4:0] o, input int a, input logic r);
    op_opc[i]  = o;
    op_addr[i] = AW'(a);
    op_rd[i]   = r;
  endtask

  task automatic drive_idle();
    sel = 1'b0; opc = '0; rd = 1'b0; addr = '0; wdata = '0;
  endtask

  // Behavioural master: runs ops 0..n-1, chained in the closing cycle when ovl=1.
  task automatic run_ops(input int n, input bit ovl, input bit stray);
    int cur = -1;
    int nxt = 0;
    int beat = 0;
    int waits = 0;
    int cyc = 0;
    bit done;
    while (cur >= 0 || nxt < n) begin
      @(negedge clk);
      drive_idle();
      done = 1'b0;
      if (cur >= 0) begin
        if (!ack_oe) begin
          chk(1'b0, "R10 ack released mid-op", 32'(ack_oe), 32'd1);
          done = 1'b1;
        end else if (ack == 3'b000) begin
          waits++;
          chk(!rdata_oe, "R10 rdata_oe in wait", 32'(rdata_oe), 32'd0);
        end else if (ack == 3'b001) begin
          logic [AW-1:0] a;
          a = op_addr[cur] + AW'(beat);
          chk(exp_beats(op_opc[cur]) > 0, "R7 ready on bad opcode", 32'(ack), 32'd2);
          if (beat == 0) chk(waits == WAITS, "R2 wait count", 32'(waits), 32'(WAITS));
          if (op_rd[cur]) begin
            chk(rdata_oe, "R10 rdata_oe on read", 32'(rdata_oe), 32'd1);
            chk(rdata === ref_m[a], "R4 R6 read data", rdata, ref_m[a]);
          end else begin
            logic [31:0] m;
            chk(!rdata_oe, "R10 rdata_oe on write", 32'(rdata_oe), 32'd0);
            wdata = 32'h9E37_79B9 * 32'(wseq);
            wseq++;
            m = exp_bits(op_opc[cur]);
            ref_m[a] = (ref_m[a] & ~m) | (wdata & m);
          end
          beat++;
          if (beat >= exp_beats(op_opc[cur])) done = 1'b1;
        end else if (ack == 3'b010) begin
          chk(exp_beats(op_opc[cur]) == 0, "R7 error on valid opcode", 32'(ack), 32'd1);
          chk(waits == 0, "R7 no wait before error", 32'(waits), 32'd0);
          done = 1'b1;
        end else begin
          chk(1'b0, "R10 bad ack code", 32'(ack), 32'd1);
          done = 1'b1;
        end
        cyc++;
        if (cyc > 100) begin
          chk(1'b0, "R3 op too long", 32'(cyc), 32'd100);
          done = 1'b1;
        end
        if (done) begin
          chk(beat == exp_beats(op_opc[cur]), "R3 beat count", 32'(beat), 32'(exp_beats(op_opc[cur])));
          cur = -1;
          if (ovl && nxt < n) begin
            // R8: next address cycle in the closing data cycle
            sel = 1'b1; opc = op_opc[nxt]; addr = op_addr[nxt]; rd = op_rd[nxt];
            cur = nxt; nxt++; beat = 0; waits = 0; cyc = 0;
          end
        end else if (stray && (cyc == 1 || cyc == 4)) begin
          // R9: stray select during wait / mid-block
          sel = 1'b1; opc = 5'b00010; rd = 1'b0; addr = AW'(50); wdata = 32'hDEAD_BEEF;
        end
      end else begin
        chk(!ack_oe && ack == 3'b111, "R10 idle ack", {28'd0, ack_oe, ack}, 32'h7);
        chk(!rdata_oe && rdata == 32'd0, "R10 idle rdata", rdata, 32'd0);
        sel = 1'b1; opc = op_opc[nxt]; addr = op_addr[nxt]; rd = op_rd[nxt];
        cur = nxt; nxt++; beat = 0; waits = 0; cyc = 0;
      end
    end
    @(negedge clk);
    drive_idle();
    chk(!ack_oe, "R9 R10 idle after ops", 32'(ack_oe), 32'd0);
  endtask

  task automatic t_reset();
    drive_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ack_oe && ack == 3'b111, "R1 reset ack", {28'd0, ack_oe, ack}, 32'h7);
    chk(!rdata_oe && rdata == 32'd0, "R1 reset rdata", rdata, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ack_oe && ack == 3'b111, "R1 after reset", {28'd0, ack_oe, ack}, 32'h7);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 4; i++) set_op(i, 5'b10011, 16 * i, 1'b0);
    run_ops(4, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) set_op(i, 5'b10011, 16 * i, 1'b1);
    run_ops(4, 1'b1, 1'b0);
    set_op(0, 5'b10000, 5, 1'b1);
    set_op(1, 5'b10001, 9, 1'b1);
    set_op(2, 5'b10010, 20, 1'b0);
    set_op(3, 5'b10010, 20, 1'b1);
    run_ops(4, 1'b0, 1'b0);
  endtask

  task automatic t_sizes();
    for (int l = 0; l < 4; l++) set_op(l, {1'b0, 2'(l), 2'b00}, 30, 1'b0);
    set_op(4, 5'b01101, 31, 1'b0);
    set_op(5, 5'b00101, 31, 1'b0);
    set_op(6, 5'b00010, 32, 1'b0);
    set_op(7, 5'b00000, 30, 1'b1);
    set_op(8, 5'b00101, 31, 1'b1);
    set_op(9, 5'b00010, 32, 1'b1);
    run_ops(10, 1'b1, 1'b0);
    // R5: lone byte write, lane 2, then word read
    set_op(0, 5'b01000, 33, 1'b0);
    set_op(1, 5'b00010, 33, 1'b1);
    run_ops(2, 1'b0, 1'b0);
  endtask

  task automatic t_error();
    set_op(0, 5'b00010, 40, 1'b1);
    set_op(1, 5'b00011, 40, 1'b0);
    set_op(2, 5'b00011, 41, 1'b0);
    set_op(3, 5'b00010, 40, 1'b1);
    set_op(4, 5'b00010, 41, 1'b1);
    run_ops(5, 1'b1, 1'b0);
  endtask

  task automatic t_ignore();
    set_op(0, 5'b10010, 8, 1'b1);
    run_ops(1, 1'b0, 1'b1);
    set_op(0, 5'b00010, 50, 1'b1);
    run_ops(1, 1'b0, 1'b0);
  endtask

  task automatic t_wrap();
    set_op(0, 5'b10001, 62, 1'b0);
    set_op(1, 5'b00010, 62, 1'b1);
    set_op(2, 5'b00010, 63, 1'b1);
    set_op(3, 5'b00010, 0, 1'b1);
    set_op(4, 5'b00010, 1, 1'b1);
    run_ops(5, 1'b1, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_m[i] = '0;
    t_reset();
    t_fill();
    t_sizes();
    t_error();
    t_ignore();
    t_wrap();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule